// File: doc/BRIEF.md
# SDRAM Command and Low-Power Manager

This block drives the command pins of two SDRAM devices that share the row-strobe, column-strobe and write-enable lines. Each device has its own chip select and its own clock enable. Software places one request at a time: a three-bit mode code, a two-bit target mask and a mode-register value. The block turns each request into the matching SDRAM command and sends it to one device or to both in the same memory-clock slot. It then holds off further requests until the command's recovery time has passed.

Each device is always in one of three states: normal, self-refresh or power-down. A device in self-refresh keeps its data with its clock enable low and no help from the controller. It wakes up when an access to it is requested or when a normal-mode request names it. A device in power-down wakes up only on a normal-mode request. A device in power-down cannot refresh itself, so the periodic refresh timer briefly raises its clock enable, sends an auto-refresh, waits the refresh recovery time and lowers the clock enable again. Devices in normal state receive the periodic auto-refresh directly.

The memory clock runs at half the system clock. Command pins and clock enables change only at the system-clock edge that ends a high phase of the memory clock, so every command is held for two system cycles.

Top module: `sdpm_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, both clock enables are 1, both chip selects are 1 (deselected), the RAS, CAS and WE lines are 1, and both devices are in normal state.
- R2: sd_clk toggles every system cycle. The command and chip-select outputs change only at the edge that follows a cycle in which sd_clk is 1.
- R3: Mode codes are 000 normal, 001 precharge-all, 010 auto-refresh, 011 load-mode, 100 self-refresh entry and 101 power-down entry. The {RAS,CAS,WE} encodings are 111 NOP, 010 PRECHARGE, 001 AUTO REFRESH, 000 LOAD MODE, 011 ACTIVE, 101 READ and 100 WRITE. Any non-NOP command has at least one chip select low.
- R4: Bit i of req_tgt selects device i (chip select bit i low). With both bits set, both chip selects go low in the same slot.
- R5: A load-mode request puts req_param on sd_mode_word in the command slot, and the value stays there afterwards.
- R6: Self-refresh entry sends AUTO REFRESH to the named devices, with their clock enable low in that same slot. A device in self-refresh always has its clock enable low.
- R7: A device in self-refresh leaves it when acc_req for that device is high while the block is idle, or on a normal-mode request that names it. The exit slot raises its clock enable and sends NOP with its chip select low. Busy then lasts cfg_exit_dly more slots.
- R8: Power-down entry lowers the clock enable of the named devices and sends no command. Only a normal-mode request ends power-down. acc_req has no effect on a device in power-down.
- R9: With cfg_ref_interval nonzero, a refresh falls due every cfg_ref_interval slots and has priority over all other work. It sends AUTO REFRESH to every device not in self-refresh. Devices in power-down get their clock enable raised one slot before the command and lowered again when the wait ends. A cfg_ref_interval of 0 disables the refresh timer.
- R10: busy goes high in the cycle after a request is accepted. It falls max(W,1) slots after the command slot, where W is 2 for precharge, cfg_trfc for auto-refresh, 2 for load-mode, cfg_exit_dly for normal mode, and 0 for self-refresh entry and power-down entry.
- R11: A request is ignored (no command, busy stays low) in these cases: it arrives while busy, its target mask is 00, its mode code is 110 or 111, or it is a non-normal mode that names a device not in normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_mode | input | 3 | Requested mode code |
| req_tgt | input | N_TGT | Target device mask |
| req_param | input | PARAM_W | Mode-register value for load-mode |
| acc_req | input | N_TGT | Access pending per device (wakes self-refresh) |
| cfg_ref_interval | input | REF_W | Refresh interval in memory-clock slots, 0 = off |
| cfg_trfc | input | DLY_W | Slots of wait after an auto-refresh |
| cfg_exit_dly | input | DLY_W | Slots of wait after a low-power exit |
| busy | output | 1 | Command or its wait in progress |
| sd_clk | output | 1 | Memory clock, half the system rate |
| sd_cke | output | N_TGT | Clock enable per device |
| sd_cs_n | output | N_TGT | Chip select per device, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_mode_word | output | PARAM_W | Value driven with the load-mode command |

## Verification
The hardest case to reach is a refresh that falls due while one device sits in power-down and the other is in normal state or in self-refresh. In that case the clock enable must rise before the command and fall after it, only for the powered-down device, and the other device must be left alone. The stimulus first steers each device into its state with ordinary requests. It then enables the refresh interval only while the block is idle and waits for the internal operation to start and finish, so the timer cannot collide with a software request. It also holds acc_req high against powered-down devices for many cycles, so that a wake path wrongly open to power-down would show up.

// File: rtl/sdpm_pkg.sv
// Shared encodings for the SDRAM command and low-power manager.
// Assumes {RAS,CAS,WE} active-low command encoding of standard SDRAM.
package sdpm_pkg;

    // Request mode codes presented by software.
    localparam logic [2:0] MODE_NORMAL    = 3'd0;
    localparam logic [2:0] MODE_PRECHARGE = 3'd1;
    localparam logic [2:0] MODE_AREF      = 3'd2;
    localparam logic [2:0] MODE_LOADMODE  = 3'd3;
    localparam logic [2:0] MODE_SELFREF   = 3'd4;
    localparam logic [2:0] MODE_PWRDOWN   = 3'd5;

    // {RAS_n, CAS_n, WE_n} command encodings.
    typedef enum logic [2:0] {
        CMD_LOADMODE  = 3'b000,
        CMD_AREF      = 3'b001,
        CMD_PRECHARGE = 3'b010,
        CMD_ACTIVE    = 3'b011,
        CMD_WRITE     = 3'b100,
        CMD_READ      = 3'b101,
        CMD_NOP       = 3'b111
    } sd_cmd_e;

    // Power state kept per device.
    typedef enum logic [1:0] {
        TS_NORMAL = 2'd0,
        TS_SELF   = 2'd1,
        TS_PDOWN  = 2'd2
    } tgt_state_e;

    // Sequencer step.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PRE  = 2'd1,
        SQ_CMD  = 2'd2,
        SQ_WAIT = 2'd3
    } sq_step_e;

endpackage

// File: rtl/sdpm_clkdiv.sv
// Divides the system clock by two for the memory clock.
// tick is high in the system cycle whose closing edge is a memory-clock slot boundary.
// Assumes synchronous active-low reset.
module sdpm_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic mclk
);
    logic ph;

    // Toggle the phase every system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    assign tick = ph;
    assign mclk = ph;
endmodule

// File: rtl/sdpm_refresh_timer.sv
// Counts memory-clock slots and raises a pending flag each refresh interval.
// An interval of zero stops the count and drops any pending refresh.
// Assumes clr is pulsed by the sequencer when it takes up the pending refresh.
module sdpm_refresh_timer #(
    parameter int REF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [REF_W-1:0] interval,
    input  logic             clr,
    output logic             pend
);
    logic [REF_W-1:0] cnt;
    logic             due;

    assign due = tick && (interval != '0) && (cnt >= interval - 1'b1);

    // Slot counter that restarts at every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || interval == '0) cnt <= '0;
        else if (tick)                cnt <= due ? '0 : cnt + 1'b1;
    end

    // Pending flag: an expiry sets it, the sequencer clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || interval == '0) pend <= 1'b0;
        else                          pend <= due | (pend & ~clr);
    end

    // R9: the counter never runs past a nonzero interval.
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (interval != '0 && $stable(interval)) |-> (cnt < interval));
endmodule

// File: rtl/sdpm_target.sv
// Power state and clock enable of one SDRAM device.
// Assumes all strobes are asserted only in tick cycles by the sequencer.
module sdpm_target
    import sdpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go_self,
    input  logic       go_pdown,
    input  logic       go_normal,
    input  logic       cke_up,
    input  logic       cke_down,
    output tgt_state_e state,
    output logic       cke
);
    // Clock-enable register, high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cke <= 1'b1;
        else if (cke_up)   cke <= 1'b1;
        else if (cke_down) cke <= 1'b0;
    end

    // Power-state register.
    always_ff @(posedge clk) begin
        if (!rst_n)         state <= TS_NORMAL;
        else if (go_self)   state <= TS_SELF;
        else if (go_pdown)  state <= TS_PDOWN;
        else if (go_normal) state <= TS_NORMAL;
    end

    // R6: a device in self-refresh never has its clock enabled.
    assert_self_cke_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_SELF) |-> !cke);

    // R2: power state moves only on slot boundaries.
    assert_state_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
endmodule

// File: rtl/sdpm_sequencer.sv
// Accepts one operation at a time (software request, self-refresh wake, or periodic
// refresh), then steps it through optional clock-enable raise, command slot and wait.
// Assumes tick marks memory-clock slot boundaries; outputs change only on those.
module sdpm_sequencer
    import sdpm_pkg::*;
#(
    parameter int N_TGT      = 2,
    parameter int PARAM_W    = 13,
    parameter int DLY_W      = 4,
    parameter int TRP_SLOTS  = 2,
    parameter int TMRD_SLOTS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [N_TGT-1:0]   req_tgt,
    input  logic [PARAM_W-1:0] req_param,
    input  logic [N_TGT-1:0]   acc_req,
    input  tgt_state_e         tstate [N_TGT],
    input  logic               ref_pend,
    input  logic [DLY_W-1:0]   cfg_trfc,
    input  logic [DLY_W-1:0]   cfg_exit_dly,
    output logic               ref_clr,
    output logic               busy,
    output logic [N_TGT-1:0]   cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [PARAM_W-1:0] mode_word,
    output logic [N_TGT-1:0]   go_self,
    output logic [N_TGT-1:0]   go_pdown,
    output logic [N_TGT-1:0]   go_normal,
    output logic [N_TGT-1:0]   cke_up,
    output logic [N_TGT-1:0]   cke_down
);
    localparam logic [DLY_W-1:0] W_TRP  = DLY_W'(TRP_SLOTS);
    localparam logic [DLY_W-1:0] W_TMRD = DLY_W'(TMRD_SLOTS);

    logic [N_TGT-1:0] self_m, pd_m, norm_m, wake_m, ref_m;
    logic             req_ok, ref_go, wake_go, sw_go, start, last;

    // Next-operation fields chosen this cycle.
    logic [N_TGT-1:0]   n_mask, n_pdm;
    sd_cmd_e            n_cmd;
    logic               n_cs, n_pre, n_relow, n_ckelo, n_ckehi, n_setst, n_ld;
    tgt_state_e         n_nst;
    logic [DLY_W-1:0]   n_wait;

    // Latched operation.
    logic [N_TGT-1:0]   op_mask, op_pdm;
    sd_cmd_e            op_cmd;
    logic               op_cs, op_pre, op_relow, op_ckelo, op_ckehi, op_setst, op_ld;
    tgt_state_e         op_nst;
    logic [DLY_W-1:0]   op_wait, cnt;
    logic [PARAM_W-1:0] op_param;
    sq_step_e           st;

    // Per-device state masks.
    always_comb begin
        for (int i = 0; i < N_TGT; i++) begin
            self_m[i] = (tstate[i] == TS_SELF);
            pd_m[i]   = (tstate[i] == TS_PDOWN);
            norm_m[i] = (tstate[i] == TS_NORMAL);
        end
    end

    assign wake_m  = acc_req & self_m;
    assign ref_m   = ~self_m;
    assign req_ok  = req_valid && (req_tgt != '0) &&
                     ((req_mode == MODE_NORMAL) ||
                      ((req_mode <= MODE_PWRDOWN) && ((req_tgt & ~norm_m) == '0)));
    assign ref_go  = ref_pend && (ref_m != '0);
    assign wake_go = !ref_pend && (wake_m != '0);
    assign sw_go   = !ref_pend && (wake_m == '0) && req_ok;
    assign start   = (st == SQ_IDLE) && (ref_go || wake_go || sw_go);
    assign ref_clr = (st == SQ_IDLE) && ref_pend;
    assign busy    = (st != SQ_IDLE);
    assign last    = tick && (st == SQ_WAIT) && (cnt <= 1);

    // Pick the operation by priority: refresh, wake, software request.
    always_comb begin
        n_mask = '0; n_pdm = '0; n_cmd = CMD_NOP; n_cs = 1'b0; n_pre = 1'b0;
        n_relow = 1'b0; n_ckelo = 1'b0; n_ckehi = 1'b0; n_setst = 1'b0;
        n_ld = 1'b0; n_nst = TS_NORMAL; n_wait = '0;
        if (ref_go) begin
            n_mask = ref_m; n_pdm = ref_m & pd_m; n_pre = |(ref_m & pd_m);
            n_relow = |(ref_m & pd_m); n_cmd = CMD_AREF; n_cs = 1'b1; n_wait = cfg_trfc;
        end else if (wake_go) begin
            n_mask = wake_m; n_cs = 1'b1; n_ckehi = 1'b1; n_setst = 1'b1;
            n_wait = cfg_exit_dly;
        end else if (sw_go) begin
            n_mask = req_tgt;
            case (req_mode)
                MODE_NORMAL: begin
                    n_mask = req_tgt & ~norm_m; n_cs = 1'b1; n_ckehi = 1'b1;
                    n_setst = 1'b1; n_wait = cfg_exit_dly;
                end
                MODE_PRECHARGE: begin n_cmd = CMD_PRECHARGE; n_cs = 1'b1; n_wait = W_TRP; end
                MODE_AREF:      begin n_cmd = CMD_AREF;      n_cs = 1'b1; n_wait = cfg_trfc; end
                MODE_LOADMODE:  begin n_cmd = CMD_LOADMODE;  n_cs = 1'b1; n_ld = 1'b1; n_wait = W_TMRD; end
                MODE_SELFREF: begin
                    n_cmd = CMD_AREF; n_cs = 1'b1; n_ckelo = 1'b1; n_setst = 1'b1; n_nst = TS_SELF;
                end
                default: begin
                    n_ckelo = 1'b1; n_setst = 1'b1; n_nst = TS_PDOWN;
                end
            endcase
        end
    end

    // Latch the chosen operation at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_mask <= '0; op_pdm <= '0; op_cmd <= CMD_NOP; op_cs <= 1'b0; op_pre <= 1'b0;
            op_relow <= 1'b0; op_ckelo <= 1'b0; op_ckehi <= 1'b0; op_setst <= 1'b0;
            op_ld <= 1'b0; op_nst <= TS_NORMAL; op_wait <= '0; op_param <= '0;
        end else if (start) begin
            op_mask <= n_mask; op_pdm <= n_pdm; op_cmd <= n_cmd; op_cs <= n_cs; op_pre <= n_pre;
            op_relow <= n_relow; op_ckelo <= n_ckelo; op_ckehi <= n_ckehi; op_setst <= n_setst;
            op_ld <= n_ld; op_nst <= n_nst; op_wait <= n_wait; op_param <= req_param;
        end
    end

    // Step through pre-raise, command slot and wait countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) st <= n_pre ? SQ_PRE : SQ_CMD;
                SQ_PRE:  if (tick) st <= SQ_CMD;
                SQ_CMD:  if (tick) begin st <= SQ_WAIT; cnt <= op_wait; end
                default: if (tick) begin
                    if (cnt <= 1) st <= SQ_IDLE;
                    else          cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Drive the command pins once per slot; deselect outside the command slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= '1; {ras_n, cas_n, we_n} <= CMD_NOP; mode_word <= '0;
        end else if (tick) begin
            cs_n <= '1;
            {ras_n, cas_n, we_n} <= CMD_NOP;
            if (st == SQ_CMD) begin
                if (op_cs) cs_n <= ~op_mask;
                {ras_n, cas_n, we_n} <= op_cmd;
                if (op_ld) mode_word <= op_param;
            end
        end
    end

    // Per-device strobes, valid only on slot boundaries.
    always_comb begin
        cke_up    = '0;
        cke_down  = '0;
        go_self   = '0;
        go_pdown  = '0;
        go_normal = '0;
        if (tick && st == SQ_PRE) cke_up = op_pdm;
        if (tick && st == SQ_CMD) begin
            if (op_ckehi) cke_up   = op_mask;
            if (op_ckelo) cke_down = op_mask;
            if (op_setst) begin
                if (op_nst == TS_SELF)       go_self   = op_mask;
                else if (op_nst == TS_PDOWN) go_pdown  = op_mask;
                else                         go_normal = op_mask;
            end
        end
        if (last && op_relow) cke_down = op_pdm;
    end

    // R7: only NOP may be sent to a device that is in self-refresh.
    assert_no_cmd_to_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == SQ_CMD && op_cs && op_cmd != CMD_NOP) |-> ((op_mask & self_m) == '0));

    // R10: once busy, busy holds until the final wait slot.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);

    // R11: a request seen while busy leaves the latched target mask untouched.
    assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(op_mask));
endmodule

// File: rtl/sdpm_cmd_ctrl.sv
// Top of the SDRAM command and low-power manager for N_TGT devices that share the
// RAS/CAS/WE lines. Software requests, access-triggered wakes and periodic refresh
// are serialised by one sequencer; each device keeps its own power state and CKE.
// Assumes one request strobe per cycle and a system clock twice the memory clock.
module sdpm_cmd_ctrl
    import sdpm_pkg::*;
#(
    parameter int N_TGT      = 2,
    parameter int PARAM_W    = 13,
    parameter int REF_W      = 12,
    parameter int DLY_W      = 4,
    parameter int TRP_SLOTS  = 2,
    parameter int TMRD_SLOTS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [N_TGT-1:0]   req_tgt,
    input  logic [PARAM_W-1:0] req_param,
    input  logic [N_TGT-1:0]   acc_req,
    input  logic [REF_W-1:0]   cfg_ref_interval,
    input  logic [DLY_W-1:0]   cfg_trfc,
    input  logic [DLY_W-1:0]   cfg_exit_dly,
    output logic               busy,
    output logic               sd_clk,
    output logic [N_TGT-1:0]   sd_cke,
    output logic [N_TGT-1:0]   sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [PARAM_W-1:0] sd_mode_word
);
    logic             tick, ref_pend, ref_clr;
    logic [N_TGT-1:0] go_self, go_pdown, go_normal, cke_up, cke_down;
    tgt_state_e       tst [N_TGT];

    sdpm_clkdiv u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .mclk (sd_clk)
    );

    sdpm_refresh_timer #(.REF_W(REF_W)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .interval(cfg_ref_interval),
        .clr     (ref_clr),
        .pend    (ref_pend)
    );

    sdpm_sequencer #(
        .N_TGT(N_TGT), .PARAM_W(PARAM_W), .DLY_W(DLY_W),
        .TRP_SLOTS(TRP_SLOTS), .TMRD_SLOTS(TMRD_SLOTS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .req_valid   (req_valid),
        .req_mode    (req_mode),
        .req_tgt     (req_tgt),
        .req_param   (req_param),
        .acc_req     (acc_req),
        .tstate      (tst),
        .ref_pend    (ref_pend),
        .cfg_trfc    (cfg_trfc),
        .cfg_exit_dly(cfg_exit_dly),
        .ref_clr     (ref_clr),
        .busy        (busy),
        .cs_n        (sd_cs_n),
        .ras_n       (sd_ras_n),
        .cas_n       (sd_cas_n),
        .we_n        (sd_we_n),
        .mode_word   (sd_mode_word),
        .go_self     (go_self),
        .go_pdown    (go_pdown),
        .go_normal   (go_normal),
        .cke_up      (cke_up),
        .cke_down    (cke_down)
    );

    // One power-state holder per device.
    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        sdpm_target u_tgt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .go_self  (go_self[g]),
            .go_pdown (go_pdown[g]),
            .go_normal(go_normal[g]),
            .cke_up   (cke_up[g]),
            .cke_down (cke_down[g]),
            .state    (tst[g]),
            .cke      (sd_cke[g])
        );

        // R8: an idle block leaves a powered-down device with its clock disabled.
        assert_pd_cke_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (tst[g] == TS_PDOWN && !busy) |-> !sd_cke[g]);
    end

    // R2: command pins move only at slot boundaries.
    assert_bus_on_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}));

    // R3: every non-NOP command selects at least one device.
    assert_cmd_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) |-> (sd_cs_n != '1));
endmodule

// File: tb/sim_sdpm_cmd_ctrl.sv
module sim_sdpm_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_tgt = '0;
    logic [12:0] req_param = '0;
    logic [1:0]  acc_req = '0;
    logic [11:0] cfg_ref_interval = '0;
    logic [3:0]  cfg_trfc = 4'd3;
    logic [3:0]  cfg_exit_dly = 4'd4;
    logic        busy, sd_clk, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_cke, sd_cs_n;
    logic [12:0] sd_mode_word;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [6:0] prev = 7'h7F;

    always #10 clk = ~clk;   // 50 MHz

    sdpm_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_tgt(req_tgt), .req_param(req_param), .acc_req(acc_req),
        .cfg_ref_interval(cfg_ref_interval), .cfg_trfc(cfg_trfc), .cfg_exit_dly(cfg_exit_dly),
        .busy(busy), .sd_clk(sd_clk), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_mode_word(sd_mode_word)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected event {cs_n[1:0], ras, cas, we, cke[1:0]}.
    task automatic push(input logic [6:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // Monitor: each slot with a chip select low, or any CKE change, is one event.
    always @(negedge clk) begin
        logic [6:0] cur;
        if (rst_n) begin
            cur = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke};
            if (cur != prev && (cur[6:5] != 2'b11 || cur[1:0] != prev[1:0])) begin
                if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected event", cur, 0);
                else begin
                    logic [6:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cur == e, t, "bus event", cur, e);
                end
            end
            prev = cur;
        end
    end

    task automatic pulse(input logic [2:0] m, input logic [1:0] t, input logic [12:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_tgt = t; req_param = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Accepted request with expected wait W; checks busy rise and length.
    task automatic run_op(input logic [2:0] m, input logic [1:0] t, input logic [12:0] p,
                          input int w, input string req);
        int n = 0;
        int lo;
        @(negedge clk);
        while (busy) @(negedge clk);
        pulse(m, t, p);
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        while (busy) begin n++; @(negedge clk); end
        lo = 2 * ((w < 1) ? 1 : w) + 1;
        chk(n >= lo && n <= lo + 1, req, "busy length", n, lo);
    endtask

    task automatic ignored(input logic [2:0] m, input logic [1:0] t, input string req);
        @(negedge clk);
        while (busy) @(negedge clk);
        pulse(m, t, 13'h0);
        repeat (6) begin
            chk(busy == 1'b0, req, "ignored request busy", busy, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(sd_cke == 2'b11, "R1", "cke", sd_cke, 3);
        chk(sd_cs_n == 2'b11, "R1", "cs_n", sd_cs_n, 3);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "rcw", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
        // R2 memory clock half rate
        begin
            logic a;
            a = sd_clk;
            @(negedge clk);
            chk(sd_clk != a, "R2", "sd_clk toggle", sd_clk, !a);
        end

        // R3 R4 precharge to device 0
        push({2'b10, 3'b010, 2'b11}, "R3");
        run_op(3'd1, 2'b01, 13'h0, 2, "R10");
        // R4 auto-refresh to both at once
        push({2'b00, 3'b001, 2'b11}, "R4");
        run_op(3'd2, 2'b11, 13'h0, 3, "R10");
        // R5 load mode to device 1
        push({2'b01, 3'b000, 2'b11}, "R5");
        run_op(3'd3, 2'b10, 13'h123, 2, "R10");
        chk(sd_mode_word == 13'h123, "R5", "mode word", sd_mode_word, 13'h123);

        // R11 invalid requests
        ignored(3'd1, 2'b00, "R11");
        ignored(3'd7, 2'b01, "R11");
        // R11 request while busy
        push({2'b10, 3'b001, 2'b11}, "R11");
        pulse(3'd2, 2'b01, 13'h0);
        pulse(3'd1, 2'b10, 13'h0);
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);

        // R6 self-refresh entry on device 0
        push({2'b10, 3'b001, 2'b10}, "R6");
        run_op(3'd4, 2'b01, 13'h0, 0, "R10");
        chk(sd_cke[0] == 1'b0, "R6", "cke0 in self-refresh", sd_cke[0], 0);
        ignored(3'd1, 2'b01, "R11");

        // R7 wake by access request
        push({2'b10, 3'b111, 2'b11}, "R7");
        begin
            int n = 0;
            acc_req = 2'b01;
            while (!busy) @(negedge clk);
            acc_req = 2'b00;
            while (busy) begin n++; @(negedge clk); end
            chk(n >= 9 && n <= 10, "R7", "exit wait", n, 9);
        end

        // R8 power-down both, access requests have no effect
        push({2'b11, 3'b111, 2'b00}, "R8");
        run_op(3'd5, 2'b11, 13'h0, 0, "R10");
        acc_req = 2'b11;
        repeat (12) begin
            @(negedge clk);
            chk(busy == 1'b0 && sd_cke == 2'b00, "R8", "acc_req in power-down", {busy, sd_cke}, 0);
        end
        acc_req = 2'b00;
        // R8 normal mode wakes device 0 only
        push({2'b10, 3'b111, 2'b01}, "R8");
        run_op(3'd0, 2'b01, 13'h0, 4, "R7");
        chk(sd_cke == 2'b01, "R8", "cke after exit", sd_cke, 1);

        // R9 refresh: device 1 powered down, device 0 normal
        push({2'b11, 3'b111, 2'b11}, "R9");
        push({2'b00, 3'b001, 2'b11}, "R9");
        push({2'b11, 3'b111, 2'b01}, "R9");
        cfg_ref_interval = 12'd12;
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        cfg_ref_interval = 12'd0;
        chk(sd_cke == 2'b01, "R9", "cke after refresh", sd_cke, 1);

        // R9 refresh skips a device in self-refresh
        push({2'b10, 3'b001, 2'b00}, "R6");
        run_op(3'd4, 2'b01, 13'h0, 0, "R10");
        push({2'b11, 3'b111, 2'b10}, "R9");
        push({2'b01, 3'b001, 2'b10}, "R9");
        push({2'b11, 3'b111, 2'b00}, "R9");
        cfg_ref_interval = 12'd10;
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        cfg_ref_interval = 12'd0;
        chk(sd_cke == 2'b00, "R9", "cke after refresh", sd_cke, 0);

        // R7 normal mode exits both low-power states
        push({2'b00, 3'b111, 2'b11}, "R7");
        run_op(3'd0, 2'b11, 13'h0, 4, "R10");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "events left over", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule